// File: doc/BRIEF.md
# I2S Audio Receive Channel

This block deserializes one I2S input line into audio samples. It can take its bit clock and word-select from outside as a slave. As a master it makes its own, using a divider of the system clock and a programmable slot length. Whichever clock is selected passes through one synchronizer and edge detector, so the capture logic behaves the same in both modes.

Each received word is 8, 16 or 32 bits, sent MSB first. The word is right-justified, zero-extended and written into an eight-entry receive queue. A CPU or a DMA engine drains the queue through a show-ahead read port. In stereo mode both slots are kept. In mono mode only the left slot is kept.

Two programmable fill thresholds drive an interrupt line and a DMA request. A soft reset empties the channel. A stop input lets the current word finish and then blocks new captures.

Top module: `i2s_rx_channel`

## Requirements
- R1: With `masterMode`=1, `sckOut` toggles every `clkDiv`+1 system clocks. `wsOut` toggles on a falling `sckOut` edge once every `wsHalf`+1 bit periods. With `masterMode`=0, both outputs are held at 0 from the next clock onward, and `sckIn`/`wsIn` are used instead.
- R2: `wordSel` selects the word length: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. A stored word appears right-justified and zero-extended on `rdData`. Slot bits after the last word bit are ignored.
- R3: Data is sampled on rising bit-clock edges, MSB first. The first bit of a word is the bit after the bit period in which word-select changed. Word-select 0 is the left slot and 1 is the right slot. In stereo mode (`monoMode`=0) both words are stored in arrival order.
- R4: With `monoMode`=1, only words from the left slot (word-select 0) are stored.
- R5: A word that completes while the queue holds eight words is dropped, and `overrun` is set. `overrun` stays set until `chanReset` or `rstN`.
- R6: The queue holds eight words, first in first out. `rdData` shows the oldest word. `rdEn` removes it when `fillLevel` is nonzero. `fillLevel` runs from 0 to 8.
- R7: `irq` is 1 exactly when `fillLevel` > `irqThresh`. `dmaReq` is 1 exactly when `fillLevel` > `dmaThresh`.
- R8: A `chanReset` pulse empties the queue, clears `overrun`, abandons any partial word and restarts the master clock generator.
- R9: While `chanStop` is 1, a word already in progress finishes and is stored, and no new word starts.
- R10: After `rstN`, `fillLevel`, `irq`, `dmaReq`, `overrun`, `sckOut` and `wsOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanReset | input | 1 | Synchronous channel reset |
| chanStop | input | 1 | Block new word captures |
| masterMode | input | 1 | 1: generate clocks, 0: use external clocks |
| monoMode | input | 1 | 1: keep left slot only |
| wordSel | input | 2 | Word length select |
| clkDiv | input | 8 | Master bit-clock half period minus one, in clocks |
| wsHalf | input | 6 | Master slot length minus one, in bits |
| sckIn | input | 1 | External bit clock |
| wsIn | input | 1 | External word select |
| sdIn | input | 1 | Serial data |
| sckOut | output | 1 | Generated bit clock |
| wsOut | output | 1 | Generated word select |
| rdEn | input | 1 | Pop the oldest word |
| rdData | output | 32 | Oldest stored word |
| fillLevel | output | 4 | Words in the queue |
| irqThresh | input | 4 | Interrupt threshold |
| dmaThresh | input | 4 | DMA threshold |
| irq | output | 1 | Fill above interrupt threshold |
| dmaReq | output | 1 | Fill above DMA threshold |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
The hardest case to reach is a word whose last bit arrives in the same bit period as the next word-select change, while stop is active. Here one tick must complete the old word and refuse to arm the new one. The stimulus streams serial data one bit behind word-select, the way a real transmitter does. It raises stop in the middle of a left word, so the left word must land in the queue and the right word must not. Master mode is closed into a loop: the bench feeds back the delayed word-select as data, which makes the expected words follow from the slot timing alone.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  localparam int unsigned WORD_MAX = 32;

  // Per-clock strobes from the control side to the datapath.
  typedef struct packed {
    logic bitTick;    // rising bit-clock edge seen this cycle
    logic startWord;  // arm a new word starting with the next tick
    logic slotRight;  // slot of the word being armed
    logic sdBit;      // data bit sampled on this tick
  } rxStrobe_t;

  function automatic logic [5:0] wordBitsOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
  import i2s_rx_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanReset,
  input  logic              chanStop,
  input  logic              masterMode,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [SLOT_W-1:0] wsHalf,
  input  logic              sckIn,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              sckOut,
  output logic              wsOut,
  output rxStrobe_t         strobe
);

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              sckGen, wsGen;

  // Master clock generator; word select changes on falling bit-clock edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      slotCnt <= '0;
      sckGen  <= 1'b0;
      wsGen   <= 1'b0;
    end else if (chanReset || !masterMode) begin
      divCnt  <= '0;
      slotCnt <= '0;
      sckGen  <= 1'b0;
      wsGen   <= 1'b0;
    end else if (divCnt == clkDiv) begin
      divCnt <= '0;
      sckGen <= ~sckGen;
      if (sckGen) begin
        if (slotCnt == wsHalf) begin
          slotCnt <= '0;
          wsGen   <= ~wsGen;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sckOut = sckGen;
  assign wsOut  = wsGen;

  // One synchronizer path for both modes keeps the sampling identical.
  logic       sckSrc, wsSrc;
  logic [2:0] sckPipe;
  logic [1:0] wsPipe, sdPipe;
  logic       wsPrev;

  assign sckSrc = masterMode ? sckGen : sckIn;
  assign wsSrc  = masterMode ? wsGen  : wsIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      wsPipe  <= '0;
      sdPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[1:0], sckSrc};
      wsPipe  <= {wsPipe[0], wsSrc};
      sdPipe  <= {sdPipe[0], sdIn};
    end
  end

  logic tick, wsChange;
  assign tick     = sckPipe[1] & ~sckPipe[2];
  assign wsChange = tick & (wsPipe[1] != wsPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     wsPrev <= 1'b0;
    else if (tick) wsPrev <= wsPipe[1];
  end

  always_comb begin
    strobe.bitTick   = tick;
    strobe.startWord = wsChange & ~chanStop;
    strobe.slotRight = wsPipe[1];
    strobe.sdBit     = sdPipe[1];
  end

endmodule

// File: rtl/i2s_rx_datapath.sv
module i2s_rx_datapath
  import i2s_rx_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanReset,
  input  logic                monoMode,
  input  logic [1:0]          wordSel,
  input  rxStrobe_t           strobe,
  input  logic                rdEn,
  output logic [WORD_MAX-1:0] rdData,
  output logic [LVL_W-1:0]    fillLevel,
  output logic                overrun
);

  logic [WORD_MAX-1:0] shiftReg, shifted, wordMask;
  logic [5:0]          bitsLeft;
  logic                slotCur;

  assign shifted = {shiftReg[WORD_MAX-2:0], strobe.sdBit};

  always_comb begin
    case (wordSel)
      2'd0:    wordMask = 32'h0000_00FF;
      2'd1:    wordMask = 32'h0000_FFFF;
      default: wordMask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      slotCur  <= 1'b0;
    end else if (chanReset) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      slotCur  <= 1'b0;
    end else if (strobe.bitTick) begin
      if (bitsLeft != 6'd0) begin
        shiftReg <= shifted;
        bitsLeft <= bitsLeft - 6'd1;
      end
      if (strobe.startWord) begin
        bitsLeft <= wordBitsOf(wordSel);
        slotCur  <= strobe.slotRight;
      end
    end
  end

  logic wordDone, pushReq, isFull, doPush, doPop;
  assign wordDone = strobe.bitTick && (bitsLeft == 6'd1);
  assign pushReq  = wordDone && !(monoMode && slotCur);
  assign isFull   = (fillLevel == LVL_W'(DEPTH));
  assign doPush   = pushReq && !isFull;
  assign doPop    = rdEn && (fillLevel != '0);

  logic [WORD_MAX-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shifted & wordMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      overrun   <= 1'b0;
    end else if (chanReset) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      overrun   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      if (pushReq && isFull) overrun <= 1'b1;
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/i2s_rx_channel.sv
module i2s_rx_channel
  import i2s_rx_pkg::*;
#(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned DIV_W  = 8,
  parameter  int unsigned SLOT_W = 6,
  localparam int unsigned LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanReset,
  input  logic                chanStop,
  input  logic                masterMode,
  input  logic                monoMode,
  input  logic [1:0]          wordSel,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic [SLOT_W-1:0]   wsHalf,
  input  logic                sckIn,
  input  logic                wsIn,
  input  logic                sdIn,
  output logic                sckOut,
  output logic                wsOut,
  input  logic                rdEn,
  output logic [WORD_MAX-1:0] rdData,
  output logic [LVL_W-1:0]    fillLevel,
  input  logic [LVL_W-1:0]    irqThresh,
  input  logic [LVL_W-1:0]    dmaThresh,
  output logic                irq,
  output logic                dmaReq,
  output logic                overrun
);

  rxStrobe_t strobe;

  i2s_rx_ctrl #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .chanStop(chanStop),
    .masterMode(masterMode), .clkDiv(clkDiv), .wsHalf(wsHalf),
    .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .sckOut(sckOut), .wsOut(wsOut), .strobe(strobe)
  );

  i2s_rx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .monoMode(monoMode),
    .wordSel(wordSel), .strobe(strobe), .rdEn(rdEn), .rdData(rdData),
    .fillLevel(fillLevel), .overrun(overrun)
  );

  assign irq    = fillLevel > irqThresh;
  assign dmaReq = fillLevel > dmaThresh;

endmodule

// File: rtl/i2s_rx_channel_chk.sv
module i2s_rx_channel_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanReset,
  input logic             masterMode,
  input logic             sckOut,
  input logic             wsOut,
  input logic [LVL_W-1:0] fillLevel,
  input logic [LVL_W-1:0] irqThresh,
  input logic             irq,
  input logic             overrun
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH)); // R6

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !chanReset |=> ({1'b0, fillLevel} <= {1'b0, $past(fillLevel)} + 1'b1)); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !chanReset |=> overrun); // R5

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    chanReset |=> (fillLevel == '0) && !overrun); // R8

  AST_IRQ_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> fillLevel > irqThresh); // R7

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> !sckOut && !wsOut); // R1

endmodule

bind i2s_rx_channel i2s_rx_channel_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanReset(chanReset), .masterMode(masterMode),
  .sckOut(sckOut), .wsOut(wsOut), .fillLevel(fillLevel),
  .irqThresh(irqThresh), .irq(irq), .overrun(overrun)
);

// File: tb/test_i2s_rx_channel.sv
module test_i2s_rx_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanReset = 1'b0, chanStop = 1'b0;
  logic        masterMode = 1'b0, monoMode = 1'b0;
  logic [1:0]  wordSel = 2'd1;
  logic [7:0]  clkDiv = 8'd2;
  logic [5:0]  wsHalf = 6'd15;
  logic        sckIn = 1'b0, wsIn = 1'b0, sdTask = 1'b0;
  logic        sdIn, sckOut, wsOut, rdEn = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  fillLevel, irqThresh = 4'd8, dmaThresh = 4'd8;
  logic        irq, dmaReq, overrun;

  logic loopOn = 1'b0, loopSd = 1'b0, lastWs = 1'b0;
  assign sdIn = loopOn ? loopSd : sdTask;

  always #2 clk = ~clk;

  i2s_rx_channel i_i2s_rx_channel (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .chanStop(chanStop),
    .masterMode(masterMode), .monoMode(monoMode), .wordSel(wordSel),
    .clkDiv(clkDiv), .wsHalf(wsHalf), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .sckOut(sckOut), .wsOut(wsOut), .rdEn(rdEn), .rdData(rdData),
    .fillLevel(fillLevel), .irqThresh(irqThresh), .dmaThresh(dmaThresh),
    .irq(irq), .dmaReq(dmaReq), .overrun(overrun)
  );

  int vectors = 0, errors = 0;
  logic pendBit = 1'b0;

  // Master loopback: data equals word select one bit period late.
  always @(negedge sckOut) if (loopOn) begin
    #1;
    loopSd = lastWs;
    lastWs = wsOut;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic driveBit(input logic ws, input logic sd);
    @(negedge clk);
    sckIn = 1'b0; wsIn = ws; sdTask = sd;
    repeat (4) @(negedge clk);
    sckIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One slot: data is sent one bit behind word select; stopAt raises chanStop.
  task automatic sendSlot(input logic ws, input logic [31:0] data, input int nBits,
                          input int slotBits, input int stopAt);
    for (int i = 0; i < slotBits; i++) begin
      logic cur;
      cur = (i < nBits) ? data[nBits-1-i] : 1'b1;
      if (i == stopAt) chanStop = 1'b1;
      driveBit(ws, pendBit);
      pendBit = cur;
    end
  endtask

  task automatic preamble();
    driveBit(1'b1, 1'b0);
    driveBit(1'b1, 1'b0);
    pendBit = 1'b0;
  endtask

  task automatic flush(input logic ws);
    driveBit(ws, pendBit);
    pendBit = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic popCheck(input string tag, input logic [31:0] exp);
    @(negedge clk);
    check(tag, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); chanReset = 1'b1;
    @(negedge clk); chanReset = 1'b0;
  endtask

  task automatic testReset();
    check("R10 fill", 32'(fillLevel), 0);
    check("R10 irq/dma/ovr", {29'd0, irq, dmaReq, overrun}, 0);
    check("R10 R1 slave clocks quiet", {30'd0, sckOut, wsOut}, 0);
  endtask

  task automatic testStereo16();
    wordSel = 2'd1;
    preamble();
    sendSlot(1'b0, 32'hA5C3, 16, 16, -1);
    sendSlot(1'b1, 32'h1234, 16, 16, -1);
    flush(1'b1);
    check("R3 R6 stereo fill", 32'(fillLevel), 2);
    popCheck("R3 left first", 32'h0000_A5C3);
    popCheck("R3 right second", 32'h0000_1234);
    check("R6 drained", 32'(fillLevel), 0);
  endtask

  task automatic testWord8();
    wordSel = 2'd0;
    preamble();
    sendSlot(1'b0, 32'h9E, 8, 16, -1);
    sendSlot(1'b1, 32'h41, 8, 16, -1);
    flush(1'b1);
    popCheck("R2 8-bit left, extra slot bits ignored", 32'h0000_009E);
    popCheck("R2 8-bit right", 32'h0000_0041);
  endtask

  task automatic testWord32();
    wordSel = 2'd2;
    preamble();
    sendSlot(1'b0, 32'hDEAD_BEEF, 32, 32, -1);
    sendSlot(1'b1, 32'h0F1E_2D3C, 32, 32, -1);
    flush(1'b1);
    popCheck("R2 32-bit left", 32'hDEAD_BEEF);
    popCheck("R2 32-bit right", 32'h0F1E_2D3C);
  endtask

  task automatic testMono();
    wordSel = 2'd1; monoMode = 1'b1;
    preamble();
    sendSlot(1'b0, 32'h1111, 16, 16, -1);
    sendSlot(1'b1, 32'h2222, 16, 16, -1);
    sendSlot(1'b0, 32'h3333, 16, 16, -1);
    sendSlot(1'b1, 32'h4444, 16, 16, -1);
    flush(1'b1);
    check("R4 mono fill", 32'(fillLevel), 2);
    popCheck("R4 mono first", 32'h1111);
    popCheck("R4 mono second", 32'h3333);
    monoMode = 1'b0;
  endtask

  task automatic testLevelsOverrun();
    wordSel = 2'd1; irqThresh = 4'd2; dmaThresh = 4'd5;
    preamble();
    for (int f = 0; f < 2; f++) begin
      sendSlot(1'b0, 32'h100 + 32'(2*f), 16, 16, -1);
      sendSlot(1'b1, 32'h101 + 32'(2*f), 16, 16, -1);
    end
    flush(1'b1);
    check("R7 irq above 2 at fill 4", {31'd0, irq}, 1);
    check("R7 dma off at fill 4", {31'd0, dmaReq}, 0);
    for (int f = 2; f < 5; f++) begin
      sendSlot(1'b0, 32'h100 + 32'(2*f), 16, 16, -1);
      sendSlot(1'b1, 32'h101 + 32'(2*f), 16, 16, -1);
    end
    flush(1'b1);
    check("R6 full at 8", 32'(fillLevel), 8);
    check("R5 overrun set", {31'd0, overrun}, 1);
    check("R7 dma on at fill 8", {31'd0, dmaReq}, 1);
    for (int k = 0; k < 8; k++) popCheck("R5 R6 kept oldest", 32'h100 + 32'(k));
    check("R7 irq off when empty", {31'd0, irq}, 0);
    check("R5 overrun sticky", {31'd0, overrun}, 1);
    irqThresh = 4'd8; dmaThresh = 4'd8;
  endtask

  task automatic testSoftReset();
    preamble();
    sendSlot(1'b0, 32'hAAAA, 16, 16, -1);
    sendSlot(1'b1, 32'h5555, 16, 16, -1);
    flush(1'b1);
    pulseReset();
    @(negedge clk);
    check("R8 fill cleared", 32'(fillLevel), 0);
    check("R8 overrun cleared", {31'd0, overrun}, 0);
  endtask

  task automatic testStop();
    preamble();
    sendSlot(1'b0, 32'hC0DE, 16, 16, 8);
    sendSlot(1'b1, 32'hBEEF, 16, 16, -1);
    flush(1'b1);
    check("R9 only in-flight word kept", 32'(fillLevel), 1);
    popCheck("R9 in-flight word", 32'hC0DE);
    chanStop = 1'b0;
  endtask

  task automatic testMaster();
    time t0;
    int waitCnt;
    driveBit(1'b0, 1'b0);
    pulseReset();
    wordSel = 2'd1; clkDiv = 8'd2; wsHalf = 6'd15;
    lastWs = 1'b0; loopSd = 1'b0; loopOn = 1'b1;
    @(negedge clk); masterMode = 1'b1;
    @(posedge sckOut); t0 = $time;
    @(posedge sckOut);
    check("R1 sck period clocks", 32'(($time - t0) / 4), 6);
    @(wsOut); t0 = $time;
    @(wsOut);
    check("R1 ws toggle clocks", 32'(($time - t0) / 4), 96);
    waitCnt = 0;
    while (fillLevel < 4'd2 && waitCnt < 4000) begin
      @(negedge clk); waitCnt++;
    end
    chanStop = 1'b1;
    popCheck("R1 R3 master right slot", 32'h0000_FFFF);
    popCheck("R1 R3 master left slot", 32'h0000_0000);
    @(negedge clk); masterMode = 1'b0; loopOn = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 master off quiet", {30'd0, sckOut, wsOut}, 0);
    chanStop = 1'b0;
    pulseReset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testStereo16();
    testWord8();
    testWord32();
    testMono();
    testLevelsOverrun();
    testSoftReset();
    testStop();
    testMaster();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule